// File: doc/BRIEF.md
# Restart Address Capture for a Pipeline with One Branch Delay Slot

This block keeps the state needed to resume after a precise trap (an exception or an external interrupt) in an in-order pipeline whose branches have one architectural delay slot. Every cycle it sees the address of the instruction at commit and a flag that says whether that instruction sits in a delay slot. It also sees a trap request and a return strobe. It drives a redirect address and a redirect valid signal to the fetch unit.

When a trap is taken, fetch has often already moved to the branch target while the delay-slot instruction is still incomplete. Resuming at the faulting instruction would then lose the branch. For a trap in a delay slot, the block therefore saves the address of the branch that owns the slot, and it sets a status bit. On return, fetch restarts at the branch. The branch runs again and rebuilds both the slot and the target, so no target address needs to be stored. If the re-run slot instruction traps again, the same rule applies and nothing is lost. The saved state lives in dedicated registers, because the handler overwrites the pipeline stages.

Top module: `exc_restart_top`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it falls, savedPc is 0, inDelaySlot is 0 and redirectValid is 0. This holds even if trapReq or trapReturn is high during reset.
- R2: A trap taken with commitInSlot low loads savedPc with commitPc, with bits [1:0] forced to 0, and clears inDelaySlot on the same clock edge.
- R3: A trap taken with commitInSlot high loads savedPc with the address 4 bytes below commitPc (bits [1:0] forced to 0 first) and sets inDelaySlot.
- R4: In the cycle trapReq is high, redirectValid is 1 and redirectPc equals the handler vector (default 0x00000080), combinationally.
- R5: In a cycle with trapReturn high and trapReq low, redirectValid is 1 and redirectPc equals the current savedPc. savedPc and inDelaySlot are left unchanged.
- R6: When trapReq and trapReturn are both high, the trap wins: redirectPc is the vector and the saved state updates as in R2/R3.
- R7: Without trapReq, savedPc and inDelaySlot hold their values. With neither strobe high, redirectValid is 0 and redirectPc is 0.
- R8: Bits [1:0] of savedPc are always 0.
- R9: After a delay-slot trap and a return, a second trap in the re-executed slot saves the same branch address and sets inDelaySlot again.
- R10: The address arithmetic wraps modulo 2^32. A delay-slot trap at address 0 saves 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commitPc | input | 32 | Address of the instruction at commit |
| commitInSlot | input | 1 | Committing instruction lies in a branch delay slot |
| trapReq | input | 1 | Take an exception or interrupt this cycle |
| trapReturn | input | 1 | Return-from-trap strobe |
| savedPc | output | 32 | Saved restart address |
| inDelaySlot | output | 1 | Last trap was taken in a delay slot |
| redirectPc | output | 32 | Fetch redirect address |
| redirectValid | output | 1 | Fetch redirect request |

## Verification
The hardest case is a second trap on a delay-slot instruction that is being re-executed after a return. Reaching it needs a chain of stimulus: a slot trap, then a return whose redirect must point at the branch, then the branch committing with no trap, then the slot trapping again. The bench drives this sequence directly and checks the saved address at each step. It also runs a delay-slot trap at address 0 to exercise wraparound. Around these it sweeps every combination of slot flag, trap and return over many aligned and unaligned addresses.

// File: rtl/restart_pkg.sv
package restart_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture; // save restart state, redirect to vector
    logic resume;  // redirect to saved address
  } ctrlStrobes_t;
endpackage

// File: rtl/restart_ctrl.sv
module restart_ctrl
  import restart_pkg::*;
(
  input  logic         rst,
  input  logic         trapReq,
  input  logic         trapReturn,
  output ctrlStrobes_t strobes,
  output logic         redirectValid
);
  always_comb begin
    strobes.capture = !rst && trapReq;
    // a trap in the same cycle takes priority over the return
    strobes.resume  = !rst && trapReturn && !trapReq;
    redirectValid   = strobes.capture || strobes.resume;
  end
endmodule

// File: rtl/restart_dp.sv
module restart_dp
  import restart_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VECTOR     = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] commitPc,
  input  logic            commitInSlot,
  input  ctrlStrobes_t    strobes,
  output logic [PC_W-1:0] savedPc,
  output logic            inDelaySlot,
  output logic [PC_W-1:0] redirectPc
);
  localparam int ALIGN_BITS = $clog2(INSN_BYTES);
  localparam logic [PC_W-1:0] ALIGN_MASK = {{(PC_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  localparam logic [PC_W-1:0] STEP       = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] VEC_PC     = PC_W'(VECTOR) & ALIGN_MASK;

  logic [PC_W-1:0] alignedPc;
  logic [PC_W-1:0] restartPc;

  always_comb begin
    alignedPc = commitPc & ALIGN_MASK;
    // a slot instruction restarts at its owning branch
    restartPc = commitInSlot ? (alignedPc - STEP) : alignedPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      savedPc     <= '0;
      inDelaySlot <= 1'b0;
    end else if (strobes.capture) begin
      savedPc     <= restartPc;
      inDelaySlot <= commitInSlot;
    end
  end

  always_comb begin
    if (strobes.capture)     redirectPc = VEC_PC;
    else if (strobes.resume) redirectPc = savedPc;
    else                     redirectPc = '0;
  end
endmodule

// File: rtl/exc_restart_top.sv
module exc_restart_top
  import restart_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VECTOR     = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] commitPc,
  input  logic            commitInSlot,
  input  logic            trapReq,
  input  logic            trapReturn,
  output logic [PC_W-1:0] savedPc,
  output logic            inDelaySlot,
  output logic [PC_W-1:0] redirectPc,
  output logic            redirectValid
);
  ctrlStrobes_t strobes;

  restart_ctrl i_ctrl (
    .rst(rst), .trapReq(trapReq), .trapReturn(trapReturn),
    .strobes(strobes), .redirectValid(redirectValid)
  );

  restart_dp #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .VECTOR(VECTOR)) i_dp (
    .clk(clk), .rst(rst), .commitPc(commitPc), .commitInSlot(commitInSlot),
    .strobes(strobes), .savedPc(savedPc), .inDelaySlot(inDelaySlot),
    .redirectPc(redirectPc)
  );
endmodule

// File: rtl/restart_chk.sv
module restart_chk #(
  parameter int          PC_W   = 32,
  parameter logic [31:0] VECTOR = 32'h0000_0080
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] commitPc,
  input logic            commitInSlot,
  input logic            trapReq,
  input logic            trapReturn,
  input logic [PC_W-1:0] savedPc,
  input logic            inDelaySlot,
  input logic [PC_W-1:0] redirectPc,
  input logic            redirectValid
);
  localparam logic [PC_W-1:0] LOW_MASK = {{(PC_W-2){1'b1}}, 2'b00};

  p_reset_quiet_r1: assert property (@(posedge clk) rst |-> !redirectValid);

  p_save_plain_r2: assert property (@(posedge clk) disable iff (rst)
    (trapReq && !commitInSlot) |=> (savedPc == ($past(commitPc) & LOW_MASK)) && !inDelaySlot);

  p_save_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (trapReq && commitInSlot) |=> (savedPc == (($past(commitPc) & LOW_MASK) - PC_W'(4))) && inDelaySlot);

  p_vector_r4: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> redirectValid && (redirectPc == PC_W'(VECTOR)));

  p_resume_r5: assert property (@(posedge clk) disable iff (rst)
    (trapReturn && !trapReq) |-> redirectValid && (redirectPc == savedPc));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !trapReq |=> $stable(savedPc) && $stable(inDelaySlot));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!trapReq && !trapReturn) |-> !redirectValid);

  p_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    savedPc[1:0] == 2'b00);
endmodule

bind exc_restart_top restart_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) i_chk (
  .clk(clk), .rst(rst), .commitPc(commitPc), .commitInSlot(commitInSlot),
  .trapReq(trapReq), .trapReturn(trapReturn), .savedPc(savedPc),
  .inDelaySlot(inDelaySlot), .redirectPc(redirectPc), .redirectValid(redirectValid)
);

// File: tb/test_exc_restart_top.sv
`timescale 1ns/1ps
module test_exc_restart_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] commitPc;
  logic        commitInSlot, trapReq, trapReturn;
  logic [31:0] savedPc, redirectPc;
  logic        inDelaySlot, redirectValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] expSaved;
  logic        expSlot;

  always #2 clk = ~clk; // 250 MHz

  exc_restart_top i_exc_restart_top (
    .clk(clk), .rst(rst), .commitPc(commitPc), .commitInSlot(commitInSlot),
    .trapReq(trapReq), .trapReturn(trapReturn), .savedPc(savedPc),
    .inDelaySlot(inDelaySlot), .redirectPc(redirectPc), .redirectValid(redirectValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // one cycle: drive after the falling edge, check outputs around it
  task automatic step(input logic [31:0] pc, input logic slot, input logic trap, input logic ret);
    string tag;
    @(negedge clk);
    commitPc = pc; commitInSlot = slot; trapReq = trap; trapReturn = ret;
    #1;
    if (trap) begin
      tag = ret ? "R6" : "R4";
      check({tag, " redirectValid"}, 32'(redirectValid), 32'd1);
      check({tag, " redirectPc"}, redirectPc, 32'h80);
    end else if (ret) begin
      check("R5 redirectValid", 32'(redirectValid), 32'd1);
      check("R5 redirectPc", redirectPc, expSaved);
    end else begin
      check("R7 redirectValid", 32'(redirectValid), 32'd0);
      check("R7 redirectPc", redirectPc, 32'd0);
    end
    if (trap) begin
      expSaved = (pc & 32'hFFFF_FFFC) - (slot ? 32'd4 : 32'd0);
      expSlot  = slot;
    end
    tag = trap ? (slot ? "R3" : "R2") : (ret ? "R5" : "R7");
    @(negedge clk);
    trapReq = 1'b0; trapReturn = 1'b0;
    check({tag, " savedPc"}, savedPc, expSaved);
    check({tag, " inDelaySlot"}, 32'(inDelaySlot), 32'(expSlot));
    check("R8 alignment", 32'(savedPc[1:0]), 32'd0);
  endtask

  initial begin
    rst = 1'b1; commitPc = 32'h1234_5678; commitInSlot = 1'b1;
    trapReq = 1'b1; trapReturn = 1'b1;
    expSaved = '0; expSlot = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 redirectValid in reset", 32'(redirectValid), 32'd0);
    check("R1 savedPc in reset", savedPc, 32'd0);
    check("R1 inDelaySlot in reset", 32'(inDelaySlot), 32'd0);
    trapReq = 1'b0; trapReturn = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 savedPc after reset", savedPc, 32'd0);
    check("R1 inDelaySlot after reset", 32'(inDelaySlot), 32'd0);
    check("R1 redirectValid after reset", 32'(redirectValid), 32'd0);

    // sweep of addresses (aligned and not) against all strobe combinations
    for (int i = 0; i < 48; i++) begin
      for (int c = 0; c < 8; c++) begin
        step(32'(i) * 32'h9E37_79B9 + 32'(c), c[0], c[1], c[2]);
      end
    end

    // R9: slot trap, return to branch, branch commits, slot traps again
    step(32'h0000_4004, 1'b1, 1'b1, 1'b0);
    check("R9 first saved branch", savedPc, 32'h0000_4000);
    step(32'h0000_0090, 1'b0, 1'b0, 1'b1);
    check("R9 return target", expSaved, 32'h0000_4000);
    step(32'h0000_4000, 1'b0, 1'b0, 1'b0);
    step(32'h0000_4004, 1'b1, 1'b1, 1'b0);
    check("R9 second saved branch", savedPc, 32'h0000_4000);
    check("R9 slot bit again", 32'(inDelaySlot), 32'd1);

    // R10: wraparound at address 0
    step(32'h0000_0000, 1'b1, 1'b1, 1'b0);
    check("R10 wrap", savedPc, 32'hFFFF_FFFC);
    step(32'h0000_0002, 1'b0, 1'b1, 1'b0);
    check("R10 plain at zero", savedPc, 32'h0000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule